// File: doc/BRIEF.md
# Deferred-Fault Tagged Register Datapath

This block holds a small register file in which every entry carries a value field, a fault-mark bit and a recovery-mark bit. It takes one decoded operation per cycle and decides what that operation writes back and whether it raises an exception. A speculative operation that faults does not trap. It stores its own program counter in the destination value field and sets the destination's fault mark. Later speculative operations that read a marked register pass the stored PC and the mark on to their own destination. A non-speculative operation that reads a marked register raises the exception and reports the stored PC. Its own fault is reported only when its sources are clean.

The block is placed between operand decode and the result bus. The ALU, the memory system and trap handling are outside it. They supply a fault flag and a result value for each operation and take the writeback and exception outputs. Both outputs are registered, so they appear one cycle after the operation is presented. A result can be read back by the very next operation, which takes it from the pending writeback.

Top module: `spec_tag_datapath`

## Requirements
- R1: A synchronous reset clears every register's fault mark and recovery mark, and clears `wb_valid` and `exc_valid`. A clean, non-faulting speculative operation issued after reset writes `wb_etag`=0.
- R2: A speculative operation whose sources both have a clear fault mark and whose `op_fault` is 1 writes `op_pc` into the destination with the fault mark set, and raises no exception.
- R3: A speculative operation with at least one marked source writes that source's value with the fault mark set and raises no exception. Its own `op_fault` and `op_result` have no effect in this case.
- R4: When both sources are marked, the value propagated or reported comes from source 1 (`op_src1`).
- R5: A non-speculative operation with a marked source asserts `exc_valid` with `exc_pc` equal to the marked source's value and does not write its destination.
- R6: A non-speculative operation with clean sources and `op_fault`=1 asserts `exc_valid` with `exc_pc`=`op_pc` and does not write its destination.
- R7: An operation with clean sources and `op_fault`=0 writes `op_result` with the fault mark cleared, whether or not it is speculative.
- R8: An operation that reads the register written by the operation in the cycle before sees the new value and marks, through bypass.
- R9: A normally executed operation sets the destination recovery mark when `op_recov` is 1 or when either source has its recovery mark set, and clears the mark otherwise. A write that propagates or records a fault clears it.
- R10: The writeback and exception outputs reflect the operation presented one clock earlier. A cycle with `op_valid`=0 produces neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | An operation is presented this cycle |
| op_spec | input | 1 | The operation is speculative |
| op_fault | input | 1 | The execution unit saw a fault for this operation |
| op_recov | input | 1 | The operation is a recovery-mode re-execution |
| op_src1 | input | AW | First source register index (priority source) |
| op_src2 | input | AW | Second source register index |
| op_dst | input | AW | Destination register index |
| op_pc | input | DW | Program counter of the operation |
| op_result | input | DW | Result value from the execution unit |
| wb_valid | output | 1 | A register write was made for the previous operation |
| wb_dst | output | AW | Register index written |
| wb_data | output | DW | Value or recorded PC written |
| wb_etag | output | 1 | Fault mark written |
| wb_rtag | output | 1 | Recovery mark written |
| exc_valid | output | 1 | The previous operation raised an exception |
| exc_pc | output | DW | PC reported with the exception |

## Verification
The assertions assume that the inputs are held at known values, with `op_valid` low, for the whole time reset is asserted. They also assume that `op_spec` is sampled in the same cycle as the operation whose outputs appear one cycle later. The bench drives every input from its declaration onward and changes inputs only on the falling edge. It keeps `op_valid` low while reset is applied and for each idle cycle. It builds fault chains through real register contents, so every expected PC follows from earlier writes that the bench itself tracks.

// File: rtl/sptag_pkg.sv
package sptag_pkg;

    parameter int DW   = 32;
    parameter int NREG = 16;
    localparam int AW  = $clog2(NREG);

    // One register entry: value or recorded PC, fault mark, recovery mark
    typedef struct packed {
        logic [DW-1:0] data;
        logic          etag;
        logic          rtag;
    } ent_t;

    // Registered stage between resolve and writeback/exception outputs
    typedef struct packed {
        logic          wb_valid;
        logic [AW-1:0] wb_dst;
        ent_t          wb_ent;
        logic          exc_valid;
        logic [DW-1:0] exc_pc;
    } stage_t;

endpackage

// File: rtl/sptag_regfile.sv
module sptag_regfile
    import sptag_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  ent_t          wdata,
    input  logic [AW-1:0] raddr1,
    input  logic [AW-1:0] raddr2,
    output ent_t          rdata1,
    output ent_t          rdata2
);

    ent_t ent_d [NREG];
    ent_t ent_q [NREG];
    logic [NREG-1:0] etag_vec;
    logic [NREG-1:0] rtag_vec;

    always_comb begin
        for (int i = 0; i < NREG; i++) begin
            ent_d[i] = ent_q[i];
            if (we && (waddr == AW'(i))) begin
                ent_d[i] = wdata;
            end
            if (rst) begin
                ent_d[i] = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NREG; i++) begin
            ent_q[i] <= ent_d[i];
        end
    end

    // Read ports with bypass from the write in flight this cycle
    always_comb begin
        rdata1 = ent_q[raddr1];
        rdata2 = ent_q[raddr2];
        if (we && (waddr == raddr1)) rdata1 = wdata;
        if (we && (waddr == raddr2)) rdata2 = wdata;
    end

    generate
        for (genvar g = 0; g < NREG; g++) begin : g_tagvec
            assign etag_vec[g] = ent_q[g].etag;
            assign rtag_vec[g] = ent_q[g].rtag;
        end
    endgenerate

    // R1: one cycle after reset is released no mark survives
    a_r1_tags_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> ($countones(etag_vec) == 0 && $countones(rtag_vec) == 0));

endmodule

// File: rtl/sptag_resolve.sv
module sptag_resolve
    import sptag_pkg::*;
(
    input  logic          op_spec,
    input  logic          op_fault,
    input  logic          op_recov,
    input  logic [DW-1:0] op_pc,
    input  logic [DW-1:0] op_result,
    input  ent_t          src1,
    input  ent_t          src2,
    output logic          wr_en,
    output ent_t          wr_ent,
    output logic          exc,
    output logic [DW-1:0] exc_pc
);

    logic          any_tag;
    logic [DW-1:0] tag_pc;
    logic          rtag_n;

    always_comb begin
        any_tag = src1.etag | src2.etag;
        // source 1 wins when both carry a mark
        tag_pc  = src1.etag ? src1.data : src2.data;
        rtag_n  = op_recov | src1.rtag | src2.rtag;

        wr_en  = 1'b0;
        wr_ent = '0;
        exc    = 1'b0;
        exc_pc = '0;

        if (op_spec) begin
            wr_en = 1'b1;
            if (any_tag) begin
                wr_ent = '{data: tag_pc, etag: 1'b1, rtag: 1'b0};
            end else if (op_fault) begin
                wr_ent = '{data: op_pc, etag: 1'b1, rtag: 1'b0};
            end else begin
                wr_ent = '{data: op_result, etag: 1'b0, rtag: rtag_n};
            end
        end else begin
            if (any_tag) begin
                exc    = 1'b1;
                exc_pc = tag_pc;
            end else if (op_fault) begin
                exc    = 1'b1;
                exc_pc = op_pc;
            end else begin
                wr_en  = 1'b1;
                wr_ent = '{data: op_result, etag: 1'b0, rtag: rtag_n};
            end
        end
    end

endmodule

// File: rtl/spec_tag_datapath.sv
module spec_tag_datapath
    import sptag_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          op_valid,
    input  logic          op_spec,
    input  logic          op_fault,
    input  logic          op_recov,
    input  logic [AW-1:0] op_src1,
    input  logic [AW-1:0] op_src2,
    input  logic [AW-1:0] op_dst,
    input  logic [DW-1:0] op_pc,
    input  logic [DW-1:0] op_result,
    output logic          wb_valid,
    output logic [AW-1:0] wb_dst,
    output logic [DW-1:0] wb_data,
    output logic          wb_etag,
    output logic          wb_rtag,
    output logic          exc_valid,
    output logic [DW-1:0] exc_pc
);

    stage_t        stg_d, stg_q;
    ent_t          rd1, rd2;
    logic          rs_wr;
    ent_t          rs_ent;
    logic          rs_exc;
    logic [DW-1:0] rs_pc;

    sptag_regfile u_rf (
        .clk    (clk),
        .rst    (rst),
        .we     (stg_q.wb_valid),
        .waddr  (stg_q.wb_dst),
        .wdata  (stg_q.wb_ent),
        .raddr1 (op_src1),
        .raddr2 (op_src2),
        .rdata1 (rd1),
        .rdata2 (rd2)
    );

    sptag_resolve u_res (
        .op_spec   (op_spec),
        .op_fault  (op_fault),
        .op_recov  (op_recov),
        .op_pc     (op_pc),
        .op_result (op_result),
        .src1      (rd1),
        .src2      (rd2),
        .wr_en     (rs_wr),
        .wr_ent    (rs_ent),
        .exc       (rs_exc),
        .exc_pc    (rs_pc)
    );

    always_comb begin
        stg_d           = '0;
        stg_d.wb_dst    = op_dst;
        stg_d.wb_ent    = rs_ent;
        stg_d.exc_pc    = rs_pc;
        stg_d.wb_valid  = op_valid & rs_wr;
        stg_d.exc_valid = op_valid & rs_exc;
        if (rst) begin
            stg_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        stg_q <= stg_d;
    end

    assign wb_valid  = stg_q.wb_valid;
    assign wb_dst    = stg_q.wb_dst;
    assign wb_data   = stg_q.wb_ent.data;
    assign wb_etag   = stg_q.wb_ent.etag;
    assign wb_rtag   = stg_q.wb_ent.rtag;
    assign exc_valid = stg_q.exc_valid;
    assign exc_pc    = stg_q.exc_pc;

    // R5: an exception never comes with a register write
    a_r5_exc_no_write: assert property (@(posedge clk) disable iff (rst)
        exc_valid |-> !wb_valid);

    // R2: a fault mark is only written by a speculative operation
    a_r2_mark_from_spec: assert property (@(posedge clk) disable iff (rst)
        (wb_valid && wb_etag) |-> $past(op_spec));

    // R6: only non-speculative operations raise exceptions
    a_r6_exc_nonspec: assert property (@(posedge clk) disable iff (rst)
        exc_valid |-> !$past(op_spec));

    // R10: an idle cycle leaves both outputs quiet
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !$past(op_valid) |-> (!wb_valid && !exc_valid));

endmodule

// File: tb/sim_spec_tag_datapath.sv
`timescale 1ns/1ps
module sim_spec_tag_datapath;
    import sptag_pkg::*;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          op_valid = 1'b0;
    logic          op_spec = 1'b0;
    logic          op_fault = 1'b0;
    logic          op_recov = 1'b0;
    logic [AW-1:0] op_src1 = '0;
    logic [AW-1:0] op_src2 = '0;
    logic [AW-1:0] op_dst = '0;
    logic [DW-1:0] op_pc = '0;
    logic [DW-1:0] op_result = '0;
    logic          wb_valid;
    logic [AW-1:0] wb_dst;
    logic [DW-1:0] wb_data;
    logic          wb_etag;
    logic          wb_rtag;
    logic          exc_valid;
    logic [DW-1:0] exc_pc;

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    spec_tag_datapath u0 (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_spec(op_spec),
        .op_fault(op_fault), .op_recov(op_recov), .op_src1(op_src1),
        .op_src2(op_src2), .op_dst(op_dst), .op_pc(op_pc),
        .op_result(op_result), .wb_valid(wb_valid), .wb_dst(wb_dst),
        .wb_data(wb_data), .wb_etag(wb_etag), .wb_rtag(wb_rtag),
        .exc_valid(exc_valid), .exc_pc(exc_pc)
    );

    task automatic chk(input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Present one operation at a falling edge; return at the next falling
    // edge, when its registered outputs are visible.
    task automatic issue(input bit spec, input bit fault, input bit recov,
                         input int s1, input int s2, input int d,
                         input logic [DW-1:0] pc, input logic [DW-1:0] res);
        op_valid  = 1'b1;
        op_spec   = spec;
        op_fault  = fault;
        op_recov  = recov;
        op_src1   = AW'(s1);
        op_src2   = AW'(s2);
        op_dst    = AW'(d);
        op_pc     = pc;
        op_result = res;
        @(negedge clk);
    endtask

    task automatic idle();
        op_valid = 1'b0;
        op_spec  = 1'b0;
        op_fault = 1'b0;
        op_recov = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1", "wb_valid after reset", DW'(wb_valid), 0);
        chk("R1", "exc_valid after reset", DW'(exc_valid), 0);
        issue(1, 0, 0, 3, 4, 5, 32'h10, 32'hA5);
        chk("R1", "mark from reset regs", DW'(wb_etag), 0);
        chk("R1", "rtag from reset regs", DW'(wb_rtag), 0);
    endtask

    task automatic t_clean();
        issue(0, 0, 0, 0, 0, 1, 32'h20, 32'h11);
        chk("R7", "nonspec clean valid", DW'(wb_valid), 1);
        chk("R7", "nonspec clean data", wb_data, 32'h11);
        chk("R7", "nonspec clean mark", DW'(wb_etag), 0);
        chk("R10", "wb_dst", DW'(wb_dst), 1);
    endtask

    task automatic t_spec_fault();
        issue(1, 1, 0, 1, 1, 2, 32'h100, 32'hDEAD);
        chk("R2", "fault pc recorded", wb_data, 32'h100);
        chk("R2", "fault mark set", DW'(wb_etag), 1);
        chk("R2", "no exception", DW'(exc_valid), 0);
        // r7 marked with 0x300 for the later no-write check
        issue(1, 1, 0, 1, 1, 7, 32'h300, 32'h0);
        chk("R2", "second recorded pc", wb_data, 32'h300);
    endtask

    task automatic t_chain();
        // three-deep chain: r2 -> r5 -> r6 -> non-speculative use
        issue(1, 0, 0, 2, 1, 5, 32'h104, 32'h55);
        chk("R3", "link1 propagated pc", wb_data, 32'h100);
        chk("R3", "link1 mark", DW'(wb_etag), 1);
        issue(1, 1, 0, 1, 5, 6, 32'h200, 32'h66);
        chk("R8", "bypassed link2 pc", wb_data, 32'h100);
        chk("R3", "own fault ignored", DW'(exc_valid), 0);
        issue(0, 0, 0, 1, 6, 7, 32'h208, 32'h77);
        chk("R5", "exc raised", DW'(exc_valid), 1);
        chk("R5", "exc pc from source", exc_pc, 32'h100);
        chk("R5", "no write", DW'(wb_valid), 0);
        idle();
        chk("R10", "idle wb", DW'(wb_valid), 0);
        chk("R10", "idle exc", DW'(exc_valid), 0);
        issue(1, 0, 0, 7, 7, 9, 32'h20C, 32'h99);
        chk("R5", "r7 kept old pc", wb_data, 32'h300);
    endtask

    task automatic t_priority();
        issue(1, 1, 0, 1, 1, 8, 32'h400, 32'h0);
        issue(1, 0, 0, 8, 2, 10, 32'h404, 32'h0);
        chk("R4", "spec src1 wins", wb_data, 32'h400);
        issue(0, 0, 0, 2, 8, 11, 32'h408, 32'h0);
        chk("R4", "nonspec src1 wins", exc_pc, 32'h100);
        issue(0, 0, 0, 1, 8, 11, 32'h40C, 32'h0);
        chk("R4", "src2 used when src1 clean", exc_pc, 32'h400);
    endtask

    task automatic t_own_fault();
        issue(0, 1, 0, 1, 1, 12, 32'h500, 32'hBEEF);
        chk("R6", "exc raised", DW'(exc_valid), 1);
        chk("R6", "own pc", exc_pc, 32'h500);
        chk("R6", "no write", DW'(wb_valid), 0);
    endtask

    task automatic t_rtag();
        issue(1, 0, 1, 1, 1, 13, 32'h600, 32'h13);
        chk("R9", "recov sets rtag", DW'(wb_rtag), 1);
        issue(0, 0, 0, 13, 1, 14, 32'h604, 32'h14);
        chk("R9", "rtag inherited", DW'(wb_rtag), 1);
        issue(0, 0, 0, 1, 1, 14, 32'h608, 32'h15);
        chk("R9", "rtag cleared", DW'(wb_rtag), 0);
        issue(1, 0, 1, 2, 2, 15, 32'h60C, 32'h0);
        chk("R9", "propagating write clears rtag", DW'(wb_rtag), 0);
    endtask

    task automatic t_clear_mark();
        issue(1, 0, 0, 1, 1, 2, 32'h700, 32'h22);
        chk("R7", "spec clean data", wb_data, 32'h22);
        chk("R7", "spec clean mark", DW'(wb_etag), 0);
        issue(0, 0, 0, 2, 2, 3, 32'h704, 32'h33);
        chk("R7", "cleared reg no exc", DW'(exc_valid), 0);
        chk("R7", "cleared reg result", wb_data, 32'h33);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_clean();
        t_spec_fault();
        t_chain();
        t_priority();
        t_own_fault();
        t_rtag();
        t_clear_mark();
        idle();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 5000 && !done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer than 5000", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule